// File: doc/BRIEF.md
# Mirrored Video Memory Controller

This block is a byte-addressed video memory that holds three equal segments (96 KiB when `BANK_AW` is 15) and presents them through a window of four segments (128 KiB). Every address is folded before use: bits above the window are discarded, and the top quarter of the window maps onto the third segment. A single synchronous request port carries a size code, an address, write data and a write enable. Reads return zero-extended little-endian data one cycle later, marked by a valid strobe.

Byte stores follow video-memory rules. The byte is written into both bytes of its halfword. A 3-bit background mode decides where the object-tile region starts, and byte stores that land in that region are discarded. Halfword and word stores always land, at naturally aligned addresses.

The control path is a small machine with three states. `ST_IDLE` means no request was taken on the previous edge. `ST_WROTE` means a store was taken. `ST_RESP` means a load was taken and its data is on the output. A taken load moves the machine to `ST_RESP`, a taken store moves it to `ST_WROTE`, and an idle cycle moves it to `ST_IDLE`, whatever the current state. `rd_valid` is high only in `ST_RESP`.

Top module: `vmem_mirror_ctrl`

## Requirements
- R1: Address bits at and above bit `BANK_AW+2` have no effect. An access at A and one at A plus any multiple of four segments reach the same byte.
- R2: A window index in the fourth segment (index 3·SEG + x) reaches the same physical byte as index 2·SEG + x, for reads and for writes.
- R3: Size codes are 0 for byte, 1 for halfword and 2 for word. A word store places data bits [7:0] at the lowest address, continuing up to bits [31:24] at address+3. A byte load at address+k returns bits [8k+7:8k] of that word.
- R4: A load accepted on one edge gives `rd_valid` = 1 for exactly the following cycle. Its data is in `rd_data`, with byte loads zero-extended above bit 7 and halfword loads zero-extended above bit 15. `rd_valid` is 0 in all other cycles.
- R5: For halfword accesses, address bit 0 is ignored. For word accesses, address bits [1:0] are ignored.
- R6: A byte store of value b writes b to both bytes of the halfword that contains the folded index.
- R7: When `bg_mode` is 0, 1 or 2, a byte store whose folded index is at or above 2·SEG leaves memory unchanged.
- R8: When `bg_mode` is 3 to 7, a byte store whose folded index is at or above 2.5·SEG leaves memory unchanged, and a byte store below that limit is accepted.
- R9: Halfword and word stores are written in every mode and at every folded index.
- R10: After reset all contents read as zero and `rd_valid` is 0.
- R11: Size code 3 behaves exactly like a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears the contents |
| req_valid | input | 1 | A request is present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | IN_AW | Byte address, folded internally |
| req_wdata | input | 32 | Store data, right-aligned for byte and halfword |
| bg_mode | input | 3 | Background mode, selects the byte-store drop limit |
| rd_valid | output | 1 | Load data is valid this cycle |
| rd_data | output | 32 | Zero-extended little-endian load data |

## Verification
The bench aims at the fold seams: the highest addresses just under each drop limit and the lowest addresses at or above them, accesses in the aliased top quarter, and address bits far above the window. A fold that dropped the alias would read zeros or a wrong segment there. A limit compare that was off by one would corrupt the byte just past the limit or lose the byte just before it. The bench also covers misaligned halfword and word addresses, byte stores to the odd byte of a halfword, and a mode switch between stores. A design that skipped the replication, or placed it in the wrong lanes, would leave a stale byte that a later word load exposes.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WROTE = 2'd1,
        ST_RESP  = 2'd2
    } port_state_e;
endpackage

// File: rtl/vmem_fold.sv
module vmem_fold #(
    parameter int BANK_AW = 9,
    parameter int IN_AW   = 32
) (
    input  logic [IN_AW-1:0]   addr_i,
    output logic [BANK_AW+1:0] idx_o
);
    localparam int IDX_W = BANK_AW + 2;

    logic [IDX_W-1:0] win;

    always_comb begin
        win = addr_i[IDX_W-1:0];
        if (win[IDX_W-1:IDX_W-2] == 2'b11)
            idx_o = {2'b10, win[BANK_AW-1:0]};
        else
            idx_o = win;
    end
endmodule

// File: rtl/vmem_lanes.sv
module vmem_lanes
    import vmem_pkg::*;
#(
    parameter int BANK_AW = 9
) (
    input  acc_size_e          size_i,
    input  logic [BANK_AW+1:0] idx_i,
    input  logic [31:0]        wdata_i,
    input  logic [2:0]         mode_i,
    input  logic               we_i,
    output logic [3:0]         be_o,
    output logic [31:0]        wword_o,
    output logic [1:0]         lane_o
);
    localparam int IDX_W = BANK_AW + 2;
    localparam logic [IDX_W-1:0] LIM_LO = IDX_W'(2 << BANK_AW);
    localparam logic [IDX_W-1:0] LIM_HI = IDX_W'(5 << (BANK_AW - 1));

    logic       drop;
    logic [3:0] be_raw;

    always_comb begin
        drop    = 1'b0;
        be_raw  = 4'b0000;
        wword_o = 32'h0;
        lane_o  = 2'b00;
        unique case (size_i)
            SZ_BYTE: begin
                lane_o  = idx_i[1:0];
                be_raw  = idx_i[1] ? 4'b1100 : 4'b0011;
                wword_o = {4{wdata_i[7:0]}};
                if (mode_i <= 3'd2)
                    drop = (idx_i >= LIM_LO);
                else
                    drop = (idx_i >= LIM_HI);
            end
            SZ_HALF: begin
                lane_o  = {idx_i[1], 1'b0};
                be_raw  = idx_i[1] ? 4'b1100 : 4'b0011;
                wword_o = {2{wdata_i[15:0]}};
            end
            SZ_WORD, SZ_WIDE: begin
                lane_o  = 2'b00;
                be_raw  = 4'b1111;
                wword_o = wdata_i;
            end
        endcase
        be_o = (we_i && !drop) ? be_raw : 4'b0000;
    end
endmodule

// File: rtl/vmem_array.sv
module vmem_array #(
    parameter int WORDS = 384,
    parameter int WA_W  = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      be_i,
    input  logic [WA_W-1:0] waddr_i,
    input  logic [31:0]     wdata_i,
    input  logic            re_i,
    input  logic [WA_W-1:0] raddr_i,
    output logic [31:0]     rword_o
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= 32'h0;
            rword_o <= 32'h0;
        end else begin
            for (int l = 0; l < 4; l++)
                if (be_i[l]) mem[waddr_i][8*l +: 8] <= wdata_i[8*l +: 8];
            if (re_i) rword_o <= mem[raddr_i];
        end
    end

    // R4: one request per cycle, so a load and a store never share an edge
    p_one_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !((|be_i) && re_i));
endmodule

// File: rtl/vmem_mirror_ctrl.sv
module vmem_mirror_ctrl
    import vmem_pkg::*;
#(
    parameter int BANK_AW = 9,
    parameter int IN_AW   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [1:0]       req_size,
    input  logic [IN_AW-1:0] req_addr,
    input  logic [31:0]      req_wdata,
    input  logic [2:0]       bg_mode,
    output logic             rd_valid,
    output logic [31:0]      rd_data
);
    localparam int IDX_W = BANK_AW + 2;
    localparam int WA_W  = BANK_AW;
    localparam int WORDS = 3 << (BANK_AW - 2);
    localparam logic [IDX_W-1:0] LIM_LO = IDX_W'(2 << BANK_AW);

    port_state_e      state_q, state_d;
    acc_size_e        rsize_q;
    logic [1:0]       rlane_q;
    logic [IDX_W-1:0] idx;
    logic [3:0]       be;
    logic [31:0]      wword;
    logic [1:0]       lane;
    logic [31:0]      rword;
    logic             is_rd;

    assign is_rd = req_valid && !req_we;

    vmem_fold #(.BANK_AW(BANK_AW), .IN_AW(IN_AW)) u_fold (
        .addr_i (req_addr),
        .idx_o  (idx)
    );

    vmem_lanes #(.BANK_AW(BANK_AW)) u_lanes (
        .size_i  (acc_size_e'(req_size)),
        .idx_i   (idx),
        .wdata_i (req_wdata),
        .mode_i  (bg_mode),
        .we_i    (req_valid && req_we),
        .be_o    (be),
        .wword_o (wword),
        .lane_o  (lane)
    );

    vmem_array #(.WORDS(WORDS), .WA_W(WA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .be_i    (be),
        .waddr_i (idx[IDX_W-1:2]),
        .wdata_i (wword),
        .re_i    (is_rd),
        .raddr_i (idx[IDX_W-1:2]),
        .rword_o (rword)
    );

    always_comb begin
        if (!req_valid)  state_d = ST_IDLE;
        else if (req_we) state_d = ST_WROTE;
        else             state_d = ST_RESP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rsize_q <= SZ_BYTE;
            rlane_q <= 2'b00;
        end else begin
            state_q <= state_d;
            if (is_rd) begin
                rsize_q <= acc_size_e'(req_size);
                rlane_q <= lane;
            end
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = 32'h0;
        unique case (state_q)
            ST_IDLE, ST_WROTE: ;
            ST_RESP: begin
                rd_valid = 1'b1;
                unique case (rsize_q)
                    SZ_BYTE: begin
                        unique case (rlane_q)
                            2'd0: rd_data = {24'h0, rword[7:0]};
                            2'd1: rd_data = {24'h0, rword[15:8]};
                            2'd2: rd_data = {24'h0, rword[23:16]};
                            2'd3: rd_data = {24'h0, rword[31:24]};
                        endcase
                    end
                    SZ_HALF:
                        rd_data = rlane_q[1] ? {16'h0, rword[31:16]} : {16'h0, rword[15:0]};
                    SZ_WORD, SZ_WIDE:
                        rd_data = rword;
                endcase
            end
            default: ;
        endcase
    end

    p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rd_valid);
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rd_valid);
    p_byte_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && req_size == 2'd0) |=> (rd_data[31:8] == 24'h0));
    p_pair_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(be) != 1) && ($countones(be) != 3));
    p_low_mode_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && req_size == 2'd0 && bg_mode <= 3'd2 && idx >= LIM_LO)
        |-> (be == 4'b0000));
    p_wide_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && req_size != 2'd0) |-> (be != 4'b0000));
endmodule

// File: tb/vmem_mirror_ctrl_test.sv
`timescale 1ns/1ps
module vmem_mirror_ctrl_test;
    localparam int BANK_AW = 9;
    localparam int SEG     = 1 << BANK_AW;
    localparam int PHYS    = 3 * SEG;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = 32'h0;
    logic [31:0] req_wdata = 32'h0;
    logic [2:0]  bg_mode = 3'd0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  model [PHYS];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    vmem_mirror_ctrl #(.BANK_AW(BANK_AW), .IN_AW(32)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .bg_mode(bg_mode), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic int fold(input logic [31:0] a);
        int w;
        w = int'(a) & (4 * SEG - 1);
        return (w >= PHYS) ? (2 * SEG + (w & (SEG - 1))) : w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_we    = 1'b0;
    endtask

    task automatic wr(input int sz, input logic [31:0] a, input logic [31:0] d, input logic [2:0] m);
        int i, h;
        bit drop;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_size = 2'(sz);
        req_addr = a; req_wdata = d; bg_mode = m;
        i = fold(a);
        if (sz == 0) begin
            drop = (m <= 3'd2) ? (i >= 2 * SEG) : (i >= 2 * SEG + SEG / 2);
            if (!drop) begin
                h = i & ~1;
                model[h] = d[7:0]; model[h+1] = d[7:0];
            end
        end else if (sz == 1) begin
            h = i & ~1;
            model[h] = d[7:0]; model[h+1] = d[15:8];
        end else begin
            h = i & ~3;
            for (int k = 0; k < 4; k++) model[h+k] = d[8*k +: 8];
        end
    endtask

    task automatic rd(input int sz, input logic [31:0] a, input string tag);
        int i, h;
        logic [31:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_size = 2'(sz); req_addr = a;
        i = fold(a);
        if (sz == 0) e = {24'h0, model[i]};
        else if (sz == 1) begin
            h = i & ~1; e = {16'h0, model[h+1], model[h]};
        end else begin
            h = i & ~3; e = {model[h+3], model[h+2], model[h+1], model[h]};
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: pops expected load results as the design returns them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R4: actual rd_valid=1 expected no pending load");
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        for (int k = 0; k < PHYS; k++) model[k] = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 rd_valid after reset", {31'h0, rd_valid}, 32'h0);

        rd(2, 32'h0, "R10");
        rd(2, 32'(2*SEG+4), "R10");
        rd(2, 32'(PHYS-4), "R10");

        wr(2, 32'h10, 32'h11223344, 3'd0);
        rd(2, 32'h10, "R3");
        rd(0, 32'h10, "R3"); rd(0, 32'h11, "R3"); rd(0, 32'h12, "R3"); rd(0, 32'h13, "R3");
        rd(1, 32'h12, "R4");
        idle();
        rd(1, 32'h13, "R5"); rd(2, 32'h13, "R5");
        wr(1, 32'h21, 32'hFFFF_BEEF, 3'd0);
        rd(2, 32'h20, "R5");

        rd(2, 32'h10 + 32'(4*SEG) + 32'h0100_0000, "R1");
        wr(2, 32'h8000_0040 + 32'(8*SEG), 32'hA1B2C3D4, 3'd0);
        rd(2, 32'h40, "R1");

        wr(2, 32'(3*SEG+'h40), 32'hCAFEF00D, 3'd0);
        rd(2, 32'(2*SEG+'h40), "R2"); rd(2, 32'(3*SEG+'h40), "R2");

        wr(0, 32'h31, 32'h5A, 3'd0);
        rd(2, 32'h30, "R6");
        wr(0, 32'h33, 32'hA5, 3'd4);
        rd(2, 32'h30, "R6");

        wr(2, 32'(2*SEG+8), 32'h12345678, 3'd0);
        wr(0, 32'(2*SEG+8), 32'hEE, 3'd2);
        rd(2, 32'(2*SEG+8), "R7");
        wr(0, 32'(3*SEG+9), 32'hEE, 3'd0);
        rd(2, 32'(2*SEG+8), "R7");
        wr(0, 32'(2*SEG-1), 32'h77, 3'd1);
        rd(2, 32'(2*SEG-4), "R7 below limit");

        wr(0, 32'(2*SEG+8), 32'hAB, 3'd3);
        rd(2, 32'(2*SEG+8), "R8");
        wr(2, 32'(2*SEG+SEG/2), 32'h01020304, 3'd0);
        wr(2, 32'(2*SEG+SEG/2-4), 32'h05060708, 3'd0);
        wr(0, 32'(2*SEG+SEG/2), 32'h99, 3'd5);
        rd(2, 32'(2*SEG+SEG/2), "R8 at limit");
        wr(0, 32'(2*SEG+SEG/2-1), 32'h66, 3'd7);
        rd(2, 32'(2*SEG+SEG/2-4), "R8 below limit");

        wr(1, 32'(2*SEG+SEG/2+'h12), 32'h0000D00D, 3'd0);
        wr(2, 32'(PHYS-4), 32'hFEEDC0DE, 3'd1);
        rd(2, 32'(2*SEG+SEG/2+'h10), "R9");
        rd(2, 32'(PHYS-4), "R9");

        wr(3, 32'h52, 32'h0BADCAFE, 3'd0);
        rd(2, 32'h50, "R11");
        rd(3, 32'h51, "R11");
        idle();
        repeat (3) @(negedge clk);
        check("R4 no pending loads", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule